// File: doc/BRIEF.md
# Flash Erase Range Planner

This block turns a single erase request into the shortest run of sector-erase commands for a serial flash command engine. A request arrives as one packed 32-bit range word: the upper half is the start and the lower half the length, both counted in 256-byte pages. The planner checks the range and then walks from start to end. At each step it issues a write-enable command and then the largest erase that fits: 64KB, 32KB or 4KB. It does not move to the next step until the flash reports that it is no longer busy.

A separate whole-chip request skips the planning and sends write-enable followed by the chip-erase opcode. While any erase operation is in progress, the planner holds a write-protect release line high. It finishes every request with a one-cycle `done` pulse and a two-bit error code. The serial protocol belongs to the command engine, which receives one command at a time over a valid/done handshake.

Top module: `erase_planner`

## Requirements
- R1: The byte start is range_word[31:16] times 256 and the byte length is range_word[15:0] times 256; every erase command carries the current byte address on cmd_addr, and write-enable and chip-erase commands carry address 0.
- R2: A range whose start or length is not a multiple of 4KB (range_word bits 19:16 or 3:0 non-zero) ends with done and err = 1, issues no command and never raises wp_release.
- R3: A range whose end (start plus length) reaches or passes 2^24 wraps the 24-bit address space; it is rejected with done and err = 1 and issues no command.
- R4: A valid zero-length range ends with done and err = 0 and issues no command.
- R5: The erase size is picked at each step, largest first: 64KB (opcode 0xD8) when the address is 64KB-aligned and address + 64KB does not pass the end; otherwise 32KB (0x52) under the same two tests at 32KB; otherwise 4KB (0x20).
- R6: Every erase command comes directly after its own write-enable command (0x06).
- R7: After each erase the planner waits until flash_busy is low and then advances the address by the size just erased; it finishes when the address reaches the end.
- R8: If flash_busy stays high for TIMEOUT consecutive polling cycles, the operation ends with done and err = 2 and the remaining steps are not issued.
- R9: A chip_req pulse issues write-enable and then opcode 0x60, waits for not-busy, and ends with done and err = 0; chip_req wins over a range_req in the same cycle.
- R10: wp_release is high whenever a command is presented and low in the cycle done is high.
- R11: A command stays on cmd_valid/cmd_op/cmd_addr, unchanged, until cmd_done is seen high; err is valid in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| range_req | input | 1 | One-cycle pulse: start a range erase |
| range_word | input | 32 | Packed range: start pages [31:16], length pages [15:0] |
| chip_req | input | 1 | One-cycle pulse: erase the whole chip |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_op | output | 8 | Flash opcode of the presented command |
| cmd_addr | output | 24 | Byte address of the presented command |
| cmd_done | input | 1 | Engine has finished the presented command |
| flash_busy | input | 1 | Flash status busy bit |
| wp_release | output | 1 | Releases the flash write protection |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 2 | 0 ok, 1 rejected range, 2 busy timeout |

## Verification
The bench sweeps every 4KB-aligned start from 0 to 92KB against every length up to 68KB. It rebuilds the expected greedy command list by arithmetic, so a planner that skipped the 32KB step, tested alignment without testing fit, or advanced by the wrong size would emit a different opcode or address list. Ranges that straddle a 64KB boundary and ranges that end exactly at the 2^24 limit are the cases where an off-by-one fit test or a missing wrap check would issue erases past the end. A flash that stays busy longer than the timeout must cut the sequence after its first erase, and misaligned ranges must not raise wp_release at all.

// File: rtl/erase_planner.sv
`timescale 1ns/1ps
module erase_planner #(
  parameter int FIELD_W      = 16,
  parameter int PAGE_SHIFT   = 8,
  parameter int SECTOR_SHIFT = 12,
  parameter int MID_SHIFT    = 15,
  parameter int BLOCK_SHIFT  = 16,
  parameter int TIMEOUT      = 1000000,
  localparam int ADDR_W      = FIELD_W + PAGE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 range_req,
  input  logic [2*FIELD_W-1:0] range_word,
  input  logic                 chip_req,
  output logic                 cmd_valid,
  output logic [7:0]           cmd_op,
  output logic [ADDR_W-1:0]    cmd_addr,
  input  logic                 cmd_done,
  input  logic                 flash_busy,
  output logic                 wp_release,
  output logic                 done,
  output logic [1:0]           err
);
  localparam int SEC_LOW = SECTOR_SHIFT - PAGE_SHIFT;
  localparam int TMR_W   = $clog2(TIMEOUT + 1);
  localparam logic [ADDR_W:0] SEC_BYTES = (ADDR_W+1)'(1) << SECTOR_SHIFT;
  localparam logic [ADDR_W:0] MID_BYTES = (ADDR_W+1)'(1) << MID_SHIFT;
  localparam logic [ADDR_W:0] BLK_BYTES = (ADDR_W+1)'(1) << BLOCK_SHIFT;
  localparam logic [7:0] OP_WREN = 8'h06, OP_E4K = 8'h20, OP_E32K = 8'h52;
  localparam logic [7:0] OP_E64K = 8'hD8, OP_CHIP = 8'h60;

  typedef enum logic [2:0] {S_IDLE, S_WREN, S_ERASE, S_POLL, S_FIN} st_t;

  st_t               st;
  logic [ADDR_W:0]   cur_q, end_q;
  logic              chip_q;
  logic [1:0]        err_q;
  logic [TMR_W-1:0]  tmr_q;

  wire [FIELD_W-1:0] hi = range_word[2*FIELD_W-1:FIELD_W];
  wire [FIELD_W-1:0] lo = range_word[FIELD_W-1:0];
  wire [ADDR_W:0] req_start = {1'b0, hi, {PAGE_SHIFT{1'b0}}};
  wire [ADDR_W:0] req_len   = {1'b0, lo, {PAGE_SHIFT{1'b0}}};
  wire [ADDR_W:0] req_end   = req_start + req_len;
  wire req_bad  = (|hi[SEC_LOW-1:0]) || (|lo[SEC_LOW-1:0]) || req_end[ADDR_W];
  wire req_zero = (lo == '0);

  wire [ADDR_W:0] remaining = end_q - cur_q;
  wire fits_blk = (cur_q[BLOCK_SHIFT-1:0] == '0) && (remaining >= BLK_BYTES);
  wire fits_mid = (cur_q[MID_SHIFT-1:0] == '0) && (remaining >= MID_BYTES);
  wire [ADDR_W:0] step     = fits_blk ? BLK_BYTES : fits_mid ? MID_BYTES : SEC_BYTES;
  wire [7:0]      erase_op = fits_blk ? OP_E64K : fits_mid ? OP_E32K : OP_E4K;
  wire [ADDR_W:0] next_cur = cur_q + step;

  assign cmd_valid  = (st == S_WREN) || (st == S_ERASE);
  assign cmd_op     = (st == S_WREN) ? OP_WREN : chip_q ? OP_CHIP : erase_op;
  assign cmd_addr   = ((st == S_WREN) || chip_q) ? '0 : cur_q[ADDR_W-1:0];
  assign wp_release = (st == S_WREN) || (st == S_ERASE) || (st == S_POLL);
  assign done       = (st == S_FIN);
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_q  <= '0;
      end_q  <= '0;
      chip_q <= 1'b0;
      err_q  <= 2'd0;
      tmr_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          tmr_q <= '0;
          if (chip_req) begin
            chip_q <= 1'b1;
            err_q  <= 2'd0;
            st     <= S_WREN;
          end else if (range_req) begin
            chip_q <= 1'b0;
            cur_q  <= req_start;
            end_q  <= req_end;
            if (req_bad) begin
              err_q <= 2'd1;
              st    <= S_FIN;
            end else begin
              err_q <= 2'd0;
              st    <= req_zero ? S_FIN : S_WREN;
            end
          end
        end
        S_WREN:  if (cmd_done) st <= S_ERASE;
        S_ERASE: if (cmd_done) begin
          tmr_q <= '0;
          st    <= S_POLL;
        end
        S_POLL: begin
          if (!flash_busy) begin
            cur_q <= next_cur;
            st    <= (chip_q || next_cur == end_q) ? S_FIN : S_WREN;
          end else if (tmr_q == TMR_W'(TIMEOUT - 1)) begin
            err_q <= 2'd2;
            st    <= S_FIN;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_planner_chk.sv
`timescale 1ns/1ps
module erase_planner_chk #(parameter int ADDR_W = 24) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_done,
  input logic              wp_release,
  input logic              done,
  input logic [1:0]        err
);
  logic [7:0] prev_op;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_op <= 8'h00;
    else if (cmd_valid && cmd_done) prev_op <= cmd_op;
  end

  wire is_erase = (cmd_op == 8'hD8) || (cmd_op == 8'h52) || (cmd_op == 8'h20);

  a_r10_wp_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> wp_release);
  a_r10_wp_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wp_release);
  a_r6_wren_before_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && (is_erase || cmd_op == 8'h60)) |-> prev_op == 8'h06);
  a_r5_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'hD8) |-> cmd_addr[15:0] == '0);
  a_r5_mid_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h52) |-> cmd_addr[14:0] == '0);
  a_r8_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err != 2'd3);
  a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind erase_planner erase_planner_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_done(cmd_done), .wp_release(wp_release),
  .done(done), .err(err));

// File: tb/erase_planner_tb_top.sv
`timescale 1ns/1ps
module erase_planner_tb_top;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        range_req = 1'b0;
  logic [31:0] range_word = '0;
  logic        chip_req = 1'b0;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic        cmd_done = 1'b0;
  logic        flash_busy = 1'b0;
  logic        wp_release, done;
  logic [1:0]  err;

  int checks = 0, errors = 0;
  int ncmd = 0, wp_bad = 0, busy_len = 0, busy_cnt = 0, lat = 0;
  int op_log [64];
  int addr_log [64];
  int exp_op [64];
  int exp_addr [64];
  int nexp;

  always #4 clk = ~clk;

  erase_planner #(.TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .range_req(range_req), .range_word(range_word),
    .chip_req(chip_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_done(cmd_done), .flash_busy(flash_busy),
    .wp_release(wp_release), .done(done), .err(err));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // command engine and flash status model
  initial begin
    forever begin
      @(negedge clk);
      if (busy_cnt > 0) busy_cnt--;
      if (!rst_n) begin
        cmd_done = 1'b0;
        lat = 0;
      end else if (cmd_done) begin
        cmd_done = 1'b0;
        lat = 0;
      end else if (cmd_valid) begin
        if (lat == 1) begin
          if (!wp_release) wp_bad++;
          if (ncmd < 64) begin
            op_log[ncmd] = int'(cmd_op);
            addr_log[ncmd] = int'(cmd_addr);
            ncmd++;
          end
          cmd_done = 1'b1;
          if (cmd_op != 8'h06) busy_cnt = busy_len;
        end else lat++;
      end
      flash_busy = (busy_cnt != 0);
    end
  end

  task automatic build_expected(input int s, input int e);
    int cur = s;
    int sz, op;
    nexp = 0;
    while (cur < e && nexp < 62) begin
      if (cur % 65536 == 0 && cur + 65536 <= e) begin sz = 65536; op = 'hD8; end
      else if (cur % 32768 == 0 && cur + 32768 <= e) begin sz = 32768; op = 'h52; end
      else begin sz = 4096; op = 'h20; end
      exp_op[nexp] = 'h06; exp_addr[nexp] = 0; nexp++;
      exp_op[nexp] = op;   exp_addr[nexp] = cur; nexp++;
      cur += sz;
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, req, "done seen", int'(done), 1);
  endtask

  task automatic compare_cmds(input string req);
    bit ok = (ncmd == nexp);
    int bad_i = -1;
    for (int i = 0; i < nexp && ok; i++)
      if (op_log[i] != exp_op[i] || addr_log[i] != exp_addr[i]) begin ok = 0; bad_i = i; end
    if (bad_i >= 0)
      check(ok, req, "command op/addr", op_log[bad_i] * 'h1000000 + addr_log[bad_i],
            exp_op[bad_i] * 'h1000000 + exp_addr[bad_i]);
    else
      check(ok, req, "command count", ncmd, nexp);
  endtask

  task automatic run_range(input int hi, input int lo, input int blen);
    int s = hi * 256;
    int l = lo * 256;
    int e = s + l;
    bit bad = (hi % 16 != 0) || (lo % 16 != 0) || (e >= (1 << 24));
    @(negedge clk);
    ncmd = 0; wp_bad = 0; busy_len = blen;
    range_word = {hi[15:0], lo[15:0]};
    range_req = 1'b1;
    @(negedge clk);
    range_req = 1'b0;
    wait_done("R7");
    if (bad) begin
      nexp = 0;
      check(err == 2'd1, (hi % 16 != 0 || lo % 16 != 0) ? "R2" : "R3", "err reject", int'(err), 1);
    end else begin
      build_expected(s, e);
      check(err == 2'd0, (l == 0) ? "R4" : "R7", "err", int'(err), 0);
    end
    compare_cmds(bad ? "R2" : (l == 0 ? "R4" : "R5"));
    check(wp_bad == 0, "R10", "wp low during command", wp_bad, 0);
    check(wp_release == 1'b0, "R10", "wp at done", int'(wp_release), 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && cmd_valid == 1'b0 && wp_release == 1'b0, "R10",
          "reset outputs", {done, cmd_valid, wp_release}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7 R1: near-exhaustive sweep of aligned starts and lengths
    for (int u = 0; u < 24; u++)
      for (int v = 0; v < 18; v++)
        run_range(u * 16, v * 16, (u + v) % 4);

    // R5: long run straddling several 64KB blocks from a 60KB start
    run_range('h0F0, 'hC80, 2);
    // R2: misaligned start, misaligned length
    run_range('h008, 'h010, 1);
    run_range('h010, 'h018, 1);
    run_range('h001, 'h000, 1);
    // R3: wraparound and end exactly at 2^24
    run_range('hFFF0, 'h0020, 1);
    run_range('hFFF0, 'h0010, 1);
    // R1: near the top of the space, valid
    run_range('hFFE0, 'h0010, 1);

    // R8: busy outlasts the timeout; only the first step is issued
    @(negedge clk);
    ncmd = 0; busy_len = TMO + 20;
    range_word = {16'h0000, 16'h0100};
    range_req = 1'b1;
    @(negedge clk);
    range_req = 1'b0;
    wait_done("R8");
    check(err == 2'd2, "R8", "timeout err", int'(err), 2);
    check(ncmd == 2, "R8", "commands before timeout", ncmd, 2);
    check(wp_release == 1'b0, "R10", "wp after timeout", int'(wp_release), 0);
    repeat (TMO + 30) @(negedge clk);

    // R9: chip erase, and chip_req wins over a simultaneous range_req
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      ncmd = 0; busy_len = 5;
      range_word = {16'h0010, 16'h0010};
      chip_req = 1'b1;
      range_req = (k == 1);
      @(negedge clk);
      chip_req = 1'b0; range_req = 1'b0;
      wait_done("R9");
      nexp = 2; exp_op[0] = 'h06; exp_addr[0] = 0; exp_op[1] = 'h60; exp_addr[1] = 0;
      check(err == 2'd0, "R9", "chip err", int'(err), 0);
      compare_cmds("R9");
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule